// File: doc/BRIEF.md
# Signed Remainder and Modulus Divider

This block divides two two's-complement integers of a parameterised width and returns three results at once. The quotient is rounded toward zero. The remainder takes the sign of the dividend. The modulus takes the sign of the divisor. A caller pulses `start` with both operands present while the block is idle. The block then runs a restoring shift-and-subtract loop on the operand magnitudes, one quotient bit per clock. It raises `done` for a single cycle, and on that cycle all three results and the zero-divisor flag are valid together.

The signs are removed before the loop and put back afterwards. The modulus is not computed by a second loop. It comes from the signed remainder: when the remainder is nonzero and the operand signs differ, the divisor is added to it. Otherwise the modulus equals the remainder. The operands are captured when the operation is accepted, so the inputs may change while the loop runs.

Top module: `sdiv_remmod`

## Requirements
- R1: A `start` seen at a rising edge while `busy` is low is accepted. `busy` is high from the next cycle on, and `done` is high for exactly one cycle, WIDTH rising edges after the accepting edge. `busy` is low during that cycle, so a new `start` may be accepted in it.
- R2: A `start` pulse, or a change of `dividend` or `divisor`, while `busy` is high has no effect on the timing or on any result of the operation in flight.
- R3: `quotient` equals the dividend divided by the divisor, truncated toward zero. It is negative when the operand signs differ and the true quotient is nonzero.
- R4: `remainder` satisfies dividend = quotient*divisor + remainder. Its magnitude is below that of the divisor, and when nonzero it has the sign of the dividend.
- R5: `modulus` satisfies dividend = divisor*N + modulus for some integer N. Its magnitude is below that of the divisor, and when nonzero it has the sign of the divisor. It equals `remainder` when the operand signs agree or the remainder is zero, and equals remainder + divisor otherwise. Example: -5 and 3 give remainder -2 and modulus 1.
- R6: A zero divisor sets `div_by_zero` during the `done` cycle and forces `quotient`, `remainder` and `modulus` to zero. `done` still comes after WIDTH cycles. `div_by_zero` is low on `done` for a nonzero divisor.
- R7: The most negative dividend divided by -1 returns the most negative value as quotient (wrap-around), with remainder and modulus both zero.
- R8: While `rst_n` is low and after its release, `busy` and `done` are low until a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | WIDTH | Signed dividend, sampled on acceptance |
| divisor | input | WIDTH | Signed divisor, sampled on acceptance |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse; results valid in this cycle |
| quotient | output | WIDTH | Signed quotient, truncated toward zero |
| remainder | output | WIDTH | Signed remainder, dividend's sign |
| modulus | output | WIDTH | Signed modulus, divisor's sign |
| div_by_zero | output | 1 | Divisor was zero (valid with done) |

## Verification
Every result is due in a single cycle: the `done` cycle, which opens WIDTH rising edges after the edge that accepted `start`. `busy` is due one edge after acceptance. The bench runs a behavioural model that counts edges from each accepted start. It compares `busy` and `done` with that model at every falling edge. It compares the three results and the flag only at the falling edge inside the model's `done` cycle. Starts issued mid-operation and in the `done` cycle itself test that acceptance follows the same edge count.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Sign facts captured when an operation is accepted
   typedef struct packed {
      logic a_neg;   // dividend negative
      logic b_neg;   // divisor negative
      logic dz;      // divisor zero
   } sdiv_sign_t;

   localparam int SDIV_MIN_WIDTH = 2;

endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
   import sdiv_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_mag,
   output logic [WIDTH-1:0] b_mag,
   output sdiv_sign_t       sign_info
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < SDIV_MIN_WIDTH) begin : g_width_chk
      $error("sdiv_operand_prep: WIDTH below minimum");
   end

   // Magnitudes are unsigned: the most negative value maps to 2**(WIDTH-1)
   always_comb begin
      sign_info.a_neg = a_in[MSB];
      sign_info.b_neg = b_in[MSB];
      sign_info.dz    = (b_in == '0);
      a_mag = a_in[MSB] ? (~a_in + 1'b1) : a_in;
      b_mag = b_in[MSB] ? (~b_in + 1'b1) : b_in;
   end

endmodule

// File: rtl/sdiv_mag_core.sv
module sdiv_mag_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] a_mag,
   input  logic [WIDTH-1:0] b_mag,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quo_mag,
   output logic [WIDTH-1:0] rem_mag
);

   localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   if (WIDTH < 2) begin : g_width_chk
      $error("sdiv_mag_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] div_q;
   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   logic [WIDTH:0]   partial;
   logic [WIDTH:0]   diff;
   logic             take;

   // One restoring step: bring down the next dividend bit, try to subtract
   always_comb begin
      partial = {rem_q, quo_q[WIDTH-1]};
      diff    = partial - {1'b0, div_q};
      take    = ~diff[WIDTH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            rem_q <= take ? diff[WIDTH-1:0] : partial[WIDTH-1:0];
            quo_q <= {quo_q[WIDTH-2:0], take};
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (load) begin
            div_q  <= b_mag;
            rem_q  <= '0;
            quo_q  <= a_mag;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign quo_mag = quo_q;
   assign rem_mag = rem_q;

   // R4: partial remainder stays below the divisor magnitude throughout the loop
   p_partial_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && div_q != '0) |-> (rem_q < div_q));

   // R1: the loop ends in a done pulse with busy dropped
   p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));

   // R2: divisor magnitude is frozen for the whole loop
   p_div_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(div_q));

endmodule

// File: rtl/sdiv_result_fix.sv
module sdiv_result_fix
   import sdiv_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [WIDTH-1:0] quo_mag,
   input  logic [WIDTH-1:0] rem_mag,
   input  logic [WIDTH-1:0] divisor_q,
   input  sdiv_sign_t       sign_info,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic [WIDTH-1:0] modulus
);

   localparam int MSB = WIDTH - 1;

   logic             signs_differ;
   logic [WIDTH-1:0] quo_s;
   logic [WIDTH-1:0] rem_s;
   logic [WIDTH-1:0] mod_s;

   always_comb begin
      signs_differ = sign_info.a_neg ^ sign_info.b_neg;
      quo_s = signs_differ    ? (~quo_mag + 1'b1) : quo_mag;
      rem_s = sign_info.a_neg ? (~rem_mag + 1'b1) : rem_mag;
      // Modulus correction: shift a nonzero remainder across zero by the divisor
      mod_s = (signs_differ && rem_mag != '0) ? (rem_s + divisor_q) : rem_s;
      if (sign_info.dz) begin
         quotient  = '0;
         remainder = '0;
         modulus   = '0;
      end else begin
         quotient  = quo_s;
         remainder = rem_s;
         modulus   = mod_s;
      end
   end

   // R4: a nonzero remainder carries the dividend's sign
   p_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sign_info.dz && remainder != '0) |-> (remainder[MSB] == sign_info.a_neg));

   // R5: a nonzero modulus carries the divisor's sign
   p_mod_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sign_info.dz && modulus != '0) |-> (modulus[MSB] == divisor_q[MSB]));

   // R6: zero divisor forces every result to zero
   p_dz_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sign_info.dz) |-> (quotient == '0 && remainder == '0 && modulus == '0));

endmodule

// File: rtl/sdiv_remmod.sv
module sdiv_remmod
   import sdiv_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic [WIDTH-1:0] modulus,
   output logic             div_by_zero
);

   if (WIDTH < SDIV_MIN_WIDTH) begin : g_width_chk
      $error("sdiv_remmod: WIDTH below minimum");
   end

   logic [WIDTH-1:0] a_mag;
   logic [WIDTH-1:0] b_mag;
   sdiv_sign_t       sign_now;
   sdiv_sign_t       sign_q;
   logic [WIDTH-1:0] divisor_q;
   logic             core_busy;
   logic             core_done;
   logic             accept;
   logic [WIDTH-1:0] quo_mag;
   logic [WIDTH-1:0] rem_mag;

   assign accept = start && !core_busy;

   sdiv_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .a_in      (dividend),
      .b_in      (divisor),
      .a_mag     (a_mag),
      .b_mag     (b_mag),
      .sign_info (sign_now)
   );

   // Sign facts and the signed divisor are held for the correction stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q    <= '0;
         divisor_q <= '0;
      end else if (accept) begin
         sign_q    <= sign_now;
         divisor_q <= divisor;
      end
   end

   sdiv_mag_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .a_mag   (a_mag),
      .b_mag   (b_mag),
      .busy    (core_busy),
      .done    (core_done),
      .quo_mag (quo_mag),
      .rem_mag (rem_mag)
   );

   sdiv_result_fix #(.WIDTH(WIDTH)) u_fix (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (core_done),
      .quo_mag   (quo_mag),
      .rem_mag   (rem_mag),
      .divisor_q (divisor_q),
      .sign_info (sign_q),
      .quotient  (quotient),
      .remainder (remainder),
      .modulus   (modulus)
   );

   assign busy        = core_busy;
   assign done        = core_done;
   assign div_by_zero = sign_q.dz;

   // R1: an accepted start raises busy on the next cycle
   p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R1: done lasts a single cycle
   p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: captured operand facts do not move while the loop runs
   p_hold_operands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(divisor_q) && $stable(sign_q)));

   // R8: idle block never reports done without a preceding loop
   p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> !done);

endmodule

// File: tb/sdiv_remmod_bench.sv
`timescale 1ns/1ps
module sdiv_remmod_bench;

   localparam int WIDTH = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [WIDTH-1:0] dividend = '0;
   logic [WIDTH-1:0] divisor = '0;
   logic             busy, done, div_by_zero;
   logic [WIDTH-1:0] quotient, remainder, modulus;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;   // 125 MHz

   sdiv_remmod #(.WIDTH(WIDTH)) u_sdiv_remmod (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder), .modulus(modulus),
      .div_by_zero(div_by_zero)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sx(input logic [WIDTH-1:0] v);
      return int'($signed(v));
   endfunction

   // Behavioural reference: edge-counting timer plus integer arithmetic
   logic m_busy = 1'b0, m_done = 1'b0;
   int   m_left = 0;
   int   e_q, e_r, e_m, e_dz;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_left == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
            m_left <= m_left - 1;
         end else if (start) begin
            int a, b, r, m;
            a = sx(dividend); b = sx(divisor);
            m_busy <= 1'b1; m_left <= WIDTH;
            if (b == 0) begin
               e_q <= 0; e_r <= 0; e_m <= 0; e_dz <= 1;
            end else begin
               r = a % b;
               m = r;
               if (r != 0 && ((r < 0) != (b < 0))) m = r + b;
               e_q <= sx(WIDTH'(a / b)); e_r <= r; e_m <= m; e_dz <= 0;
            end
         end
      end
   end

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 busy", int'(busy), int'(m_busy));
         chk("R1 done", int'(done), int'(m_done));
         if (m_done) begin
            chk("R3 quotient",  sx(quotient),  e_q);
            chk("R4 remainder", sx(remainder), e_r);
            chk("R5 modulus",   sx(modulus),   e_m);
            chk("R6 div_by_zero", int'(div_by_zero), e_dz);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic run_op(input int a, input int b);
      @(negedge clk);
      while (busy) @(negedge clk);
      dividend = WIDTH'(a); divisor = WIDTH'(b); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      int seed = 7;
      // R8: reset state
      #3;
      chk("R8 busy in reset", int'(busy), 0);
      chk("R8 done in reset", int'(done), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 busy idle", int'(busy), 0);
      chk("R8 done idle", int'(done), 0);

      // R3 R4 R5: sign combinations
      run_op(5, 3);   run_op(-5, 3);  run_op(-5, -3); run_op(5, -3);
      run_op(9, -4);  run_op(-9, 4);  run_op(0, 5);   run_op(3, 7);
      run_op(-3, 7);  run_op(127, -128); run_op(-128, -128); run_op(-128, 1);
      // R6: zero divisor
      run_op(7, 0);   run_op(0, 0);   run_op(-128, 0);
      // R7: overflow wrap
      run_op(-128, -1);
      chk("R7 wrap quotient", sx(quotient), -128);
      chk("R7 wrap remainder", sx(remainder), 0);
      chk("R7 wrap modulus", sx(modulus), 0);

      // R5 explicit example, checked at the done cycle
      run_op(-5, 3);
      chk("R5 modulus of -5 by 3", sx(modulus), 1);
      chk("R4 remainder of -5 by 3", sx(remainder), -2);

      // R2: start and operand change mid-flight are ignored
      @(negedge clk);
      dividend = WIDTH'(100); divisor = WIDTH'(-7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      dividend = WIDTH'(-1); divisor = WIDTH'(2); start = 1'b1;
      @(negedge clk);
      start = 1'b0; dividend = WIDTH'(55);
      while (!done) @(negedge clk);
      chk("R2 quotient kept", sx(quotient), -14);
      chk("R2 modulus kept", sx(modulus), -5);

      // R1: start in the done cycle is accepted
      dividend = WIDTH'(-50); divisor = WIDTH'(6); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 back-to-back busy", int'(busy), 1);
      while (!done) @(negedge clk);

      // Pseudo-random operands
      for (int i = 0; i < 200; i++) begin
         int a, b;
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         a = sx(WIDTH'(seed >> 8));
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         b = sx(WIDTH'(seed >> 12));
         run_op(a, b);
      end

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule